// File: doc/BRIEF.md
# Aggregated Interrupt Cause Controller

This block collects hardware interrupt events into three 32-bit cause groups (transmit, receive and miscellaneous). Each group keeps its own cause, mask and clear-mode state, so software can pick per bit whether a cause clears when it is read or when a 1 is written to it. A summary register reduces each group to one pending bit, a software summary mask gates those bits, and one interrupt line goes to the host.

Software reaches every register through a simple single-cycle write port and a read port. Read data is registered and appears the cycle after the read is accepted. The address is five bits wide. Bits [4:3] pick the group (0 transmit, 1 receive, 2 miscellaneous, 3 summary) and bits [2:0] pick the register inside the group.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset every cause register and every clear-mode register is 0. Every group mask and the summary mask are all ones, and `irq_o` is 0.
- R2: A 1 on a hardware event input sets the matching cause bit on the next clock edge. If a clear hits the same bit in the same cycle, the event wins and the bit stays set.
- R3: Writing offset 0 of a group clears each cause bit whose clear-mode bit is 0 and whose written bit is 1. Cause bits whose clear-mode bit is 1 ignore such writes.
- R4: Reading offset 0 returns the cause value as it was before the read. The read then clears every bit whose clear-mode bit is 1. Bits whose clear-mode bit is 0 are not changed by the read.
- R5: Writing ones to offset 2 sets those mask bits and writing ones to offset 3 clears them. All other mask bits keep their value. Offset 4 reads back the mask.
- R6: Writing offset 1 forces the written 1 bits of the cause register to 1.
- R7: Offset 5 returns the cause ANDed with the inverted mask, and reading it clears nothing.
- R8: Address 24 is the summary register, with bit 0 for transmit, bit 1 for receive and bit 2 for miscellaneous. A bit is set while its group has any unmasked pending cause. Reading the register returns its value and clears it, unless the group is still pending.
- R9: Address 25 is the 3-bit summary mask, which can be read and written. `irq_o` is the registered OR of the summary bits whose mask bit is 0, and all ones keeps `irq_o` low.
- R10: Offset 6 is the clear-mode register, which can be read and written (1 = clear on read, 0 = write 1 to clear).
- R11: Clear mode and mask act per bit. For example, the miscellaneous bit 27 can stay write-1-to-clear and unmasked while every other bit of the group is clear-on-read and masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address (group, offset) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read address (group, offset) |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| evt_tx | input | 32 | Transmit group hardware events |
| evt_rx | input | 32 | Receive group hardware events |
| evt_misc | input | 32 | Miscellaneous group hardware events |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench drives a hardware event into the same bit that a write-1-to-clear or a clear-on-read targets in the same cycle. A design that let the clear win would lose that event for good. It checks that a clear-on-read read returns the value from before the read and still leaves write-1-to-clear bits set; a design that returned the cleared value or cleared every bit fails here. It reads the summary register while a group is still pending, where a design that cleared unconditionally would show a summary of zero next to a live cause. It also runs the mixed clear-mode and mask case on miscellaneous bit 27, which catches any logic that treats the group as a whole. Random traffic against a reference model then covers the timing of the summary and of the interrupt line.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int GROUPS = 3;
  localparam int ADDR_W = 5;
  localparam int OFS_W  = 3;
  localparam int GSEL_W = ADDR_W - OFS_W;

  typedef enum logic [OFS_W-1:0] {
    OFS_CAUSE  = 3'd0,
    OFS_SWSET  = 3'd1,
    OFS_MSET   = 3'd2,
    OFS_MCLR   = 3'd3,
    OFS_MVAL   = 3'd4,
    OFS_MASKED = 3'd5,
    OFS_MODE   = 3'd6
  } grp_ofs_e;

  typedef enum logic [OFS_W-1:0] {
    SUM_PSEUDO = 3'd0,
    SUM_MASK   = 3'd1
  } sum_ofs_e;
endpackage

// File: rtl/irq_cause_group.sv
module irq_cause_group #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] wdata_i,
  input  logic         we_cause,
  input  logic         we_set,
  input  logic         we_mset,
  input  logic         we_mclr,
  input  logic         we_mode,
  input  logic         re_cause,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] mode_o,
  output logic         pend_o
);
  logic [W-1:0] cause_q, mask_q, mode_q;
  logic [W-1:0] clr_bits, set_bits, cause_nxt;

  always_comb begin
    clr_bits  = (re_cause ? mode_q : '0) | (we_cause ? (wdata_i & ~mode_q) : '0);
    set_bits  = evt_i | (we_set ? wdata_i : '0);
    cause_nxt = (cause_q & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      cause_q <= cause_nxt;
      if (we_mset)      mask_q <= mask_q | wdata_i;
      else if (we_mclr) mask_q <= mask_q & ~wdata_i;
      if (we_mode)      mode_q <= wdata_i;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
  assign pend_o  = |(cause_q & ~mask_q);

  p_event_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));
  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (we_cause && !we_set) |=> ((cause_q & $past(wdata_i & ~mode_q & ~evt_i)) == '0));
  p_cor_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (re_cause && !we_set) |=> ((cause_q & $past(mode_q & ~evt_i)) == '0));
  p_mask_set_r5: assert property (@(posedge clk) disable iff (rst)
    we_mset |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  p_mask_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (we_mclr && !we_mset) |=> ((mask_q & $past(wdata_i)) == '0));
  p_swset_r6: assert property (@(posedge clk) disable iff (rst)
    we_set |=> ((cause_q & $past(wdata_i)) == $past(wdata_i)));
endmodule

// File: rtl/irq_cause_summary.sv
module irq_cause_summary #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_i,
  input  logic         re_pseudo,
  input  logic         we_smask,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] pseudo_o,
  output logic [N-1:0] smask_o,
  output logic         irq_o
);
  logic [N-1:0] pseudo_q, smask_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pseudo_q <= '0;
      smask_q  <= '1;
      irq_q    <= 1'b0;
    end else begin
      pseudo_q <= (re_pseudo ? '0 : pseudo_q) | pend_i;
      if (we_smask) smask_q <= wdata_i;
      irq_q <= |(pseudo_q & ~smask_q);
    end
  end

  assign pseudo_o = pseudo_q;
  assign smask_o  = smask_q;
  assign irq_o    = irq_q;

  p_pend_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (|pend_i) |=> ((pseudo_q & $past(pend_i)) == $past(pend_i)));
  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    re_pseudo |=> (pseudo_q == $past(pend_i)));
  p_smask_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (smask_q == '1) |=> !irq_o);
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      evt_tx,
  input  logic [W-1:0]      evt_rx,
  input  logic [W-1:0]      evt_misc,
  output logic              irq_o
);
  logic [GROUPS-1:0][W-1:0] evt_all;
  logic [W-1:0]             cause [GROUPS];
  logic [W-1:0]             mask  [GROUPS];
  logic [W-1:0]             mode  [GROUPS];
  logic [W-1:0]             grp_rd [GROUPS];
  logic [GROUPS-1:0]        pend;
  logic [GROUPS-1:0]        pseudo, smask;
  logic [GSEL_W-1:0]        wr_grp, rd_grp;
  logic [OFS_W-1:0]         wr_ofs, rd_ofs;
  logic [W-1:0]             rd_mux;

  assign evt_all = {evt_misc, evt_rx, evt_tx};
  assign wr_grp  = wr_addr[ADDR_W-1:OFS_W];
  assign wr_ofs  = wr_addr[OFS_W-1:0];
  assign rd_grp  = rd_addr[ADDR_W-1:OFS_W];
  assign rd_ofs  = rd_addr[OFS_W-1:0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic wr_hit, rd_hit;
    assign wr_hit = wr_en && (wr_grp == GSEL_W'(g));
    assign rd_hit = rd_en && (rd_grp == GSEL_W'(g));

    irq_cause_group #(.W(W)) u_grp (
      .clk      (clk),
      .rst      (rst),
      .evt_i    (evt_all[g]),
      .wdata_i  (wr_data),
      .we_cause (wr_hit && (wr_ofs == OFS_CAUSE)),
      .we_set   (wr_hit && (wr_ofs == OFS_SWSET)),
      .we_mset  (wr_hit && (wr_ofs == OFS_MSET)),
      .we_mclr  (wr_hit && (wr_ofs == OFS_MCLR)),
      .we_mode  (wr_hit && (wr_ofs == OFS_MODE)),
      .re_cause (rd_hit && (rd_ofs == OFS_CAUSE)),
      .cause_o  (cause[g]),
      .mask_o   (mask[g]),
      .mode_o   (mode[g]),
      .pend_o   (pend[g])
    );

    always_comb begin
      case (rd_ofs)
        OFS_CAUSE:  grp_rd[g] = cause[g];
        OFS_MVAL:   grp_rd[g] = mask[g];
        OFS_MASKED: grp_rd[g] = cause[g] & ~mask[g];
        OFS_MODE:   grp_rd[g] = mode[g];
        default:    grp_rd[g] = '0;
      endcase
    end
  end

  irq_cause_summary #(.N(GROUPS)) u_sum (
    .clk       (clk),
    .rst       (rst),
    .pend_i    (pend),
    .re_pseudo (rd_en && (rd_grp == GSEL_W'(GROUPS)) && (rd_ofs == SUM_PSEUDO)),
    .we_smask  (wr_en && (wr_grp == GSEL_W'(GROUPS)) && (wr_ofs == SUM_MASK)),
    .wdata_i   (wr_data[GROUPS-1:0]),
    .pseudo_o  (pseudo),
    .smask_o   (smask),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < GROUPS; g++)
      if (rd_grp == GSEL_W'(g)) rd_mux = grp_rd[g];
    if (rd_grp == GSEL_W'(GROUPS)) begin
      if (rd_ofs == SUM_PSEUDO)    rd_mux = W'(pseudo);
      else if (rd_ofs == SUM_MASK) rd_mux = W'(smask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  p_masked_read_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_grp == 2'd0) && (rd_ofs == OFS_MASKED) && !wr_en && (evt_tx == '0))
    |=> (cause[0] == $past(cause[0])));
endmodule

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;
  localparam int W = 32;
  localparam logic [4:0] A_PSEUDO = 5'd24;
  localparam logic [4:0] A_SMASK  = 5'd25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic [W-1:0] evt_tx = '0, evt_rx = '0, evt_misc = '0;
  logic irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_cause [3];
  logic [W-1:0] m_mask  [3];
  logic [W-1:0] m_mode  [3];
  logic [2:0]   m_smask, m_pseudo;

  always #4 clk = ~clk;

  irq_cause_ctrl #(.W(W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_tx(evt_tx), .evt_rx(evt_rx), .evt_misc(evt_misc), .irq_o(irq_o)
  );

  function automatic logic [4:0] ga(input int g, input int ofs);
    return 5'(g * 8 + ofs);
  endfunction

  function automatic logic [2:0] m_pend();
    logic [2:0] p;
    for (int g = 0; g < 3; g++) p[g] = |(m_cause[g] & ~m_mask[g]);
    return p;
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [4:0] a);
    int g;
    g = int'(a[4:3]);
    if (g == 3) begin
      if (a[2:0] == 3'd0) return W'(m_pseudo);
      if (a[2:0] == 3'd1) return W'(m_smask);
      return '0;
    end
    case (a[2:0])
      3'd0: return m_cause[g];
      3'd4: return m_mask[g];
      3'd5: return m_cause[g] & ~m_mask[g];
      3'd6: return m_mode[g];
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input string tag, input bit we, input logic [4:0] wa, input logic [W-1:0] wd,
                    input bit re, input logic [4:0] ra,
                    input logic [W-1:0] et, input logic [W-1:0] er, input logic [W-1:0] em);
    logic [W-1:0] exp_rd, clr, setb;
    logic [W-1:0] ev [3];
    logic [2:0] pend_pre;
    logic exp_irq;
    exp_rd   = exp_read(ra);
    exp_irq  = |(m_pseudo & ~m_smask);
    pend_pre = m_pend();
    ev[0] = et; ev[1] = er; ev[2] = em;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    evt_tx = et; evt_rx = er; evt_misc = em;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; evt_tx = '0; evt_rx = '0; evt_misc = '0;
    if (re) check(tag, rd_data, exp_rd);
    check({tag, " irq"}, W'(irq_o), W'(exp_irq));
    for (int g = 0; g < 3; g++) begin
      clr  = ((re && ra == ga(g, 0)) ? m_mode[g] : '0) |
             ((we && wa == ga(g, 0)) ? (wd & ~m_mode[g]) : '0);
      setb = ev[g] | ((we && wa == ga(g, 1)) ? wd : '0);
      m_cause[g] = (m_cause[g] & ~clr) | setb;
      if (we && wa == ga(g, 2)) m_mask[g] = m_mask[g] | wd;
      if (we && wa == ga(g, 3)) m_mask[g] = m_mask[g] & ~wd;
      if (we && wa == ga(g, 6)) m_mode[g] = wd;
    end
    if (we && wa == A_SMASK) m_smask = wd[2:0];
    m_pseudo = ((re && ra == A_PSEUDO) ? 3'b0 : m_pseudo) | pend_pre;
  endtask

  task automatic wr(input string tag, input logic [4:0] a, input logic [W-1:0] d);
    op(tag, 1'b1, a, d, 1'b0, '0, '0, '0, '0);
  endtask

  task automatic rd(input string tag, input logic [4:0] a);
    op(tag, 1'b0, '0, '0, 1'b1, a, '0, '0, '0);
  endtask

  task automatic idle(input string tag);
    op(tag, 1'b0, '0, '0, 1'b0, '0, '0, '0, '0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int g = 0; g < 3; g++) begin
      m_cause[g] = '0; m_mask[g] = '1; m_mode[g] = '0;
    end
    m_smask = 3'b111; m_pseudo = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int g = 0; g < 3; g++) begin
      rd("R1 cause", ga(g, 0));
      rd("R1 mask", ga(g, 4));
      rd("R1 mode", ga(g, 6));
    end
    rd("R1 pseudo", A_PSEUDO);
    rd("R1 smask", A_SMASK);

    // R6 software set, R3 write-1-to-clear, R2 event beats clear
    wr("R6 swset", ga(0, 1), 32'h0000_0005);
    rd("R6 cause", ga(0, 0));
    wr("R3 w1c", ga(0, 0), 32'h0000_0001);
    rd("R3 cause", ga(0, 0));
    op("R2 evt vs w1c", 1'b1, ga(0, 0), 32'h0000_0004, 1'b0, '0, 32'h0000_0004, '0, '0);
    rd("R2 cause", ga(0, 0));
    op("R2 evt only", 1'b0, '0, '0, 1'b0, '0, '0, 32'h8000_0000, '0);
    rd("R2 rx cause", ga(1, 0));

    // R10 mode readback, R4 clear-on-read
    wr("R10 mode", ga(1, 6), 32'h0000_000F);
    rd("R10 mode rd", ga(1, 6));
    op("R4 evt", 1'b0, '0, '0, 1'b0, '0, '0, 32'h0000_0011, '0);
    rd("R4 first read", ga(1, 0));
    rd("R4 second read", ga(1, 0));
    wr("R3 write ignored by cor bits", ga(1, 0), 32'h0000_000F);
    rd("R3 cor bits kept", ga(1, 0));
    op("R4 evt vs cor", 1'b0, '0, '0, 1'b1, ga(1, 0), '0, 32'h0000_0002, '0);
    rd("R4 evt kept", ga(1, 0));

    // R5 mask set/clear, R7 masked readback
    wr("R5 mclr", ga(2, 3), 32'h0000_00F0);
    rd("R5 mval", ga(2, 4));
    wr("R5 mset", ga(2, 2), 32'h0000_0030);
    rd("R5 mval2", ga(2, 4));
    wr("R7 swset", ga(2, 1), 32'h0000_00FF);
    rd("R7 masked", ga(2, 5));
    rd("R7 masked again", ga(2, 5));
    rd("R7 raw kept", ga(2, 0));

    // R8 summary, R9 interrupt gating
    repeat (3) idle("R9 masked quiet");
    rd("R8 pseudo", A_PSEUDO);
    wr("R9 smask", A_SMASK, 32'h0000_0003);
    repeat (3) idle("R9 irq on");
    wr("R8 clear misc", ga(2, 0), 32'hFFFF_FFFF);
    rd("R8 pseudo still", A_PSEUDO);
    rd("R8 pseudo cleared", A_PSEUDO);
    repeat (3) idle("R9 irq off");
    wr("R9 smask off", A_SMASK, 32'h0000_0007);

    // R11 misc bit 27 independent
    wr("R11 mode", ga(2, 6), 32'hF7FF_FFFF);
    wr("R11 unmask all", ga(2, 3), 32'hFFFF_FFFF);
    wr("R11 mask others", ga(2, 2), 32'hF7FF_FFFF);
    op("R11 evt", 1'b0, '0, '0, 1'b0, '0, '0, '0, 32'hFFFF_FFFF);
    rd("R11 masked", ga(2, 5));
    rd("R11 cor read", ga(2, 0));
    rd("R11 bit27 left", ga(2, 0));
    wr("R11 w1c 27", ga(2, 0), 32'h0800_0000);
    rd("R11 cleared", ga(2, 0));

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      int g, o;
      logic [W-1:0] d;
      g = int'($urandom_range(0, 3));
      o = (g == 3) ? int'($urandom_range(0, 1)) : int'($urandom_range(0, 6));
      d = $urandom;
      if (o == 2 || o == 3) d = d & $urandom;
      op("R8 random", ($urandom_range(0, 1) == 1), ga(g, o), d,
         ($urandom_range(0, 1) == 1), ga(int'($urandom_range(0, 3)), int'($urandom_range(0, 6))),
         $urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
         $urandom & $urandom & $urandom);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule